// File: doc/BRIEF.md
# Start/Busy Handshake Worker Sequencer

This block is a subordinate state machine that a controlling state machine calls the way software calls a subroutine. It shares the clock and the reset of its caller. It waits in an idle state until the caller raises `start_i`. It then steps through a fixed chain of `N_STEPS` work states, one per clock, and returns to idle on its own. Only the sequencing and the handshake are built here. The per-state datapath work is left to the logic that surrounds the block.

`busy_o` tells the caller that a call is running. It rises in the first work state, which confirms that the call was accepted. It falls in the last work state, one cycle before the block is back in idle. A caller that reacts to the falling edge therefore reissues `start_i` exactly when the block can accept it, and no cycle is lost between jobs. `done_o` marks the last work state. `step_o` exposes the current state so the sequence can be observed.

Top module: `mm_worker_fsm`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `step_o` is 0 and both `busy_o` and `done_o` are 0.
- R2: In idle (`step_o` = 0), the block stays idle on every clock at which `start_i` is low.
- R3: A clock that samples `start_i` high in idle moves the block to work state 1, and `busy_o` is high in that state.
- R4: The work states are numbered 1 to `N_STEPS` on `step_o`. From state k < `N_STEPS` the block moves to state k+1 on the next clock.
- R5: `busy_o` is high in work states 1 to `N_STEPS`-1, which is `N_STEPS`-1 cycles per job, and low in state `N_STEPS` and in idle.
- R6: From state `N_STEPS` the block always returns to idle on the next clock, whatever the value of `start_i`.
- R7: `start_i` has no effect while a job is running. It neither restarts nor lengthens the sequence.
- R8: `done_o` is high for exactly one cycle per job, in state `N_STEPS`, which is the cycle in which `busy_o` falls.
- R9: With `start_i` held high, the block begins a new job every `N_STEPS`+1 cycles. A start issued in the cycle after `busy_o` falls is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Call request, sampled in idle only |
| busy_o | output | 1 | A job is running; falls one cycle early |
| done_o | output | 1 | One-cycle strobe in the last work state |
| step_o | output | $clog2(N_STEPS+1) | Current state: 0 idle, 1..N_STEPS work |

## Verification
If the state register held a wrong value, `step_o` would show it in the very next cycle, because every cycle of every job is compared with an index that the bench derives from the number of cycles since acceptance. A wrong branch in the last state, such as waiting there or taking a start, would leave `step_o` nonzero one cycle after `done_o` and would shift every later job when `start_i` is held high. A misplaced busy decode would show as `busy_o` being high for one cycle too many or too few, or as `busy_o` falling in a cycle other than the one in which `done_o` is high. The sweep drives every pattern of `start_i` noise over the work cycles, so a start that leaks into a running job would show up as a restart within one cycle.

// File: rtl/mm_worker_pkg.sv
package mm_worker_pkg;
  function automatic int step_width(input int n_steps);
    return $clog2(n_steps + 1);
  endfunction
endpackage

// File: rtl/mm_worker_seq.sv
module mm_worker_seq #(
  parameter int N_STEPS = 4,
  localparam int W = mm_worker_pkg::step_width(N_STEPS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic [W-1:0] step_o
);
  localparam logic [W-1:0] LAST = W'(N_STEPS);

  logic [W-1:0] step_q, step_d;

  always_comb begin
    if (step_q == '0)        step_d = start_i ? W'(1) : '0;
    else if (step_q == LAST) step_d = '0;  // last state never waits
    else                     step_d = step_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == '0 && !start_i) |=> step_q == '0);
  // R3
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == '0 && start_i) |=> step_q == W'(1));
  // R6
  last_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == LAST |=> step_q == '0);
  // R4
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != '0 && step_q != LAST) |=> step_q == W'($past(step_q) + W'(1)));
endmodule

// File: rtl/mm_worker_flags.sv
module mm_worker_flags #(
  parameter int N_STEPS = 4,
  localparam int W = mm_worker_pkg::step_width(N_STEPS)
) (
  input  logic [W-1:0] step_i,
  output logic         busy_o,
  output logic         done_o
);
  localparam logic [W-1:0] LAST = W'(N_STEPS);

  // busy drops in the last state so the caller can restart with no gap
  assign busy_o = (step_i != '0) && (step_i != LAST);
  assign done_o = (step_i == LAST);
endmodule

// File: rtl/mm_worker_fsm.sv
module mm_worker_fsm #(
  parameter int N_STEPS = 4,
  localparam int W = mm_worker_pkg::step_width(N_STEPS)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] step_o
);
  if (N_STEPS < 2) begin : g_bad_cfg
    initial $error("N_STEPS must be at least 2");
  end

  logic [W-1:0] step;

  mm_worker_seq #(.N_STEPS(N_STEPS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .step_o (step)
  );

  mm_worker_flags #(.N_STEPS(N_STEPS)) u_flags (
    .step_i(step),
    .busy_o(busy_o),
    .done_o(done_o)
  );

  assign step_o = step;

  // R3
  busy_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == '0 && start_i) |=> busy_o);
  // R8
  done_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  // R7
  busy_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> step == W'($past(step) + W'(1)));
endmodule

// File: tb/sim_mm_worker_fsm.sv
module sim_mm_worker_fsm;
  localparam int N = 4;
  localparam int W = $clog2(N + 1);
  localparam time PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done;
  logic [W-1:0] step;

  int n_run = 0;
  int n_fail = 0;

  always #(PERIOD / 2) clk = ~clk;

  mm_worker_fsm #(.N_STEPS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .step_o(step)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input int exp_step);
    bit exp_busy = (exp_step != 0) && (exp_step != N);
    bit exp_done = (exp_step == N);
    chk(int'(step) == exp_step, {tag, " step"}, int'(step), exp_step);
    chk(busy == exp_busy, {tag, " busy"}, int'(busy), int'(exp_busy));
    chk(done == exp_done, {tag, " done"}, int'(done), int'(exp_done));
  endtask

  // One job: start in idle, then noise on start per bit of pat during work states.
  task automatic run_job(input int pat);
    int busy_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      chk_state(i == 1 ? "R3 accept" : (i == N ? "R8 R5 last" : "R4 R7 advance"), i);
      if (busy) busy_cnt++;
      start = pat[i-1];
    end
    @(negedge clk);
    chk_state("R6 return", 0);
    chk(busy_cnt == N - 1, "R5 busy length", busy_cnt, N - 1);
    start = 1'b0;
    @(negedge clk);
    chk_state("R2 idle hold", 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: during reset, with start high
    start = 1'b1;
    #(PERIOD * 2 + 1);
    chk_state("R1 in reset", 0);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after release", 0);

    // R2: idle with start low
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk_state("R2 idle", 0);
    end

    // R7 R6: every start-noise pattern across the work states
    for (int pat = 0; pat < (1 << N); pat++) run_job(pat);

    // R9: start held high, jobs back to back every N+1 cycles
    @(negedge clk);
    start = 1'b1;
    for (int c = 1; c <= 3 * (N + 1); c++) begin
      @(negedge clk);
      chk_state("R9 back-to-back", c % (N + 1));
    end
    start = 1'b0;

    // R1: asynchronous reset mid-job
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk_state("R1 async mid-job", 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 released", 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule